// File: doc/BRIEF.md
# Looping Trace Sequencer

This block replaces a host core while a short straight-line trace runs over and over as a loop. The host writes live-in values into a small internal register file, loads a configuration memory with one word per bundle, and pulses `start` with the index of the first bundle and the number of bundles in the trace. The sequencer then takes the bundles one at a time, in trace order. Each bundle passes through a configure phase, an execute phase and a writeback phase. The length of each phase comes from that bundle's own configuration word. After the last bundle the sequencer returns to the first, and the next iteration begins.

Each bundle drives a single-operation ALU stub. It reads its operands from the register file, holds the result in a latch and writes it back only in the writeback phase. Stores collect in a small buffer. The buffer drains to data memory once an iteration has finished cleanly. A failing guard, or a store that would overflow the buffer, is a side exit. On a side exit the iteration is squashed, the buffered stores are thrown away, and the register file returns to its checkpoint from the start of that iteration. The live-out values then stream back to the host, and a done pulse reports which bundle caused the exit.

The configuration depth must be a power of two. The trace index wraps modulo that depth.

Top module: `trace_seq`

## Requirements
- R1: After reset, `done`, `lo_valid` and `mem_we` are all low.
- R2: While idle, a `li_we` write sets register `li_idx` to `li_data`. After a side exit, every register is presented once on `lo_idx`/`lo_data` with `lo_valid` high, in index order 0 to NREG-1, one per cycle.
- R3: Configuration word fields, counted from bit 0, are: op[2:0], ra, rb and rd (RW bits each), imm (IMMW bits, sign-extended), cfg latency bit, exe latency code (3 bits), wb latency bit. The op codes are: 0 rd=ra+rb, 1 rd=ra-rb, 2 rd=ra&rb, 3 rd=ra^rb, 4 rd=ra+imm, 5 store value rb at address ra, 6 guard that fails when ra==rb, 7 no operation. Ops 5 to 7 write no register.
- R4: Phase lengths are: configure 1+bit cycles; execute min(code+1, 5) cycles; writeback 1+bit cycles. Only one bundle is active at a time. Each iteration adds one checkpoint cycle. A side exit leaves out the exiting bundle's writeback and adds one squash cycle.
- R5: Bundle k of the trace uses configuration entry (start+k) mod depth. A length of 0 is treated as 1. After bundle len-1 the next iteration starts again at bundle 0.
- R6: Stores appear on the memory port only after their iteration completes. They appear in issue order, one per cycle, and the iteration's drain takes one cycle more than its store count.
- R7: A failing guard squashes the iteration. Its buffered stores never reach memory, and the live-outs show the register values from the start of the squashed iteration.
- R8: A store that would be the (SBDEPTH+1)-th in one iteration forces a side exit at that bundle, before the store is buffered.
- R9: `done` is high for one cycle, in the cycle after the last live-out. `exit_idx` then holds the configuration index of the bundle that caused the exit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration memory write enable |
| cfg_addr | input | CAW | Configuration entry to write |
| cfg_wdata | input | CW | Configuration word |
| li_we | input | 1 | Live-in write enable (idle only) |
| li_idx | input | RW | Live-in register index |
| li_data | input | DW | Live-in value |
| start | input | 1 | Begin running the trace |
| tr_start | input | CAW | Configuration index of the first bundle |
| tr_len | input | CAW+1 | Number of bundles in the trace |
| lo_valid | output | 1 | Live-out value valid |
| lo_idx | output | RW | Live-out register index |
| lo_data | output | DW | Live-out value |
| mem_we | output | 1 | Data memory store strobe |
| mem_addr | output | DW | Store address |
| mem_wdata | output | DW | Store data |
| done | output | 1 | End-of-run pulse |
| exit_idx | output | CAW | Configuration index of the exiting bundle |

## Verification
The assertions take the host's side of the contract as given. `start` and live-in writes arrive only while the block is idle. The configuration memory stays unchanged while a trace runs. Every trace the host starts contains a guard that fails in some iteration, so every run ends in a side exit. The bench keeps to this: it writes configuration and live-ins only before each `start`, and it waits for `done` before touching anything else. It also builds each trace with a counter or a fixed condition that is known to trip the guard, or the buffer overflow, within a few iterations.

// File: rtl/trace_seq.sv
module trace_seq #(
  parameter int NREG    = 8,
  parameter int DW      = 16,
  parameter int CDEPTH  = 16,
  parameter int SBDEPTH = 4,
  parameter int IMMW    = 8,
  localparam int RW     = $clog2(NREG),
  localparam int CAW    = $clog2(CDEPTH),
  localparam int CW     = 3 + 3*RW + IMMW + 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [CAW-1:0] cfg_addr,
  input  logic [CW-1:0]  cfg_wdata,
  input  logic           li_we,
  input  logic [RW-1:0]  li_idx,
  input  logic [DW-1:0]  li_data,
  input  logic           start,
  input  logic [CAW-1:0] tr_start,
  input  logic [CAW:0]   tr_len,
  output logic           lo_valid,
  output logic [RW-1:0]  lo_idx,
  output logic [DW-1:0]  lo_data,
  output logic           mem_we,
  output logic [DW-1:0]  mem_addr,
  output logic [DW-1:0]  mem_wdata,
  output logic           done,
  output logic [CAW-1:0] exit_idx
);
  localparam int SBW  = $clog2(SBDEPTH + 1);
  localparam int SBI  = $clog2(SBDEPTH);
  localparam int F_RA = 3;
  localparam int F_RB = F_RA + RW;
  localparam int F_RD = F_RB + RW;
  localparam int F_IM = F_RD + RW;
  localparam int F_CL = F_IM + IMMW;
  localparam int F_EL = F_CL + 1;
  localparam int F_WL = F_EL + 3;

  typedef enum logic [3:0] {
    S_IDLE, S_CKPT, S_CFG, S_EXE, S_WB, S_DRAIN, S_SQ, S_LOUT, S_DONE
  } st_t;

  st_t            st;
  logic [CW-1:0]  cram [CDEPTH];
  logic [DW-1:0]  rf   [NREG];
  logic [DW-1:0]  ck   [NREG];
  logic [DW-1:0]  sba  [SBDEPTH];
  logic [DW-1:0]  sbd  [SBDEPTH];
  logic [SBW-1:0] sb_n, dn;
  logic [CAW:0]   pos, len;
  logic [CAW-1:0] base, exit_q;
  logic [2:0]     cnt;
  logic [DW-1:0]  res;
  logic [RW-1:0]  lo_i;

  wire [CAW-1:0] idx  = base + pos[CAW-1:0];
  wire [CW-1:0]  cw   = cram[idx];
  wire [2:0]     op   = cw[2:0];
  wire [DW-1:0]  a    = rf[cw[F_RA +: RW]];
  wire [DW-1:0]  b    = rf[cw[F_RB +: RW]];
  wire [DW-1:0]  imm  = {{(DW-IMMW){cw[F_IM+IMMW-1]}}, cw[F_IM +: IMMW]};
  wire [2:0]     elc  = cw[F_EL +: 3];
  wire [2:0]     elast = (elc > 3'd4) ? 3'd4 : elc;
  wire cfg_end = (cnt == {2'b0, cw[F_CL]});
  wire exe_end = (cnt == elast);
  wire wb_end  = (cnt == {2'b0, cw[F_WL]});
  wire is_st   = (op == 3'd5);
  wire exit_now = ((op == 3'd6) && (a == b)) || (is_st && (sb_n == SBW'(SBDEPTH)));

  logic [DW-1:0] alu;
  always_comb begin
    case (op)
      3'd0:    alu = a + b;
      3'd1:    alu = a - b;
      3'd2:    alu = a & b;
      3'd3:    alu = a ^ b;
      3'd4:    alu = a + imm;
      default: alu = a;
    endcase
  end

  always_ff @(posedge clk)
    if (cfg_we) cram[cfg_addr] <= cfg_wdata;

  always_ff @(posedge clk)
    if (st == S_WB && wb_end && is_st) begin
      sba[sb_n[SBI-1:0]] <= a;
      sbd[sb_n[SBI-1:0]] <= b;
    end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      sb_n <= '0; dn <= '0; pos <= '0; len <= '0;
      base <= '0; exit_q <= '0; cnt <= '0; res <= '0; lo_i <= '0;
      for (int i = 0; i < NREG; i++) begin
        rf[i] <= '0;
        ck[i] <= '0;
      end
    end else begin
      case (st)
        S_IDLE: begin
          if (li_we) rf[li_idx] <= li_data;
          if (start) begin
            base <= tr_start;
            len  <= (tr_len == '0) ? (CAW+1)'(1) : tr_len;
            sb_n <= '0;
            st   <= S_CKPT;
          end
        end
        S_CKPT: begin
          for (int i = 0; i < NREG; i++) ck[i] <= rf[i];
          pos <= '0; cnt <= '0;
          st  <= S_CFG;
        end
        S_CFG: begin
          if (cfg_end) begin cnt <= '0; st <= S_EXE; end
          else cnt <= cnt + 3'd1;
        end
        S_EXE: begin
          if (exe_end) begin
            cnt <= '0;
            res <= alu;
            if (exit_now) begin exit_q <= idx; st <= S_SQ; end
            else st <= S_WB;
          end else cnt <= cnt + 3'd1;
        end
        S_WB: begin
          if (wb_end) begin
            cnt <= '0;
            if (op <= 3'd4) rf[cw[F_RD +: RW]] <= res;
            if (is_st) sb_n <= sb_n + 1'b1;
            if (pos == len - 1'b1) begin dn <= '0; st <= S_DRAIN; end
            else begin pos <= pos + 1'b1; st <= S_CFG; end
          end else cnt <= cnt + 3'd1;
        end
        S_DRAIN: begin
          if (dn == sb_n) begin sb_n <= '0; st <= S_CKPT; end
          else dn <= dn + 1'b1;
        end
        S_SQ: begin
          for (int i = 0; i < NREG; i++) rf[i] <= ck[i];
          sb_n <= '0; lo_i <= '0;
          st   <= S_LOUT;
        end
        S_LOUT: begin
          lo_i <= lo_i + 1'b1;
          if (lo_i == RW'(NREG-1)) st <= S_DONE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign lo_valid  = (st == S_LOUT);
  assign lo_idx    = lo_i;
  assign lo_data   = rf[lo_i];
  assign mem_we    = (st == S_DRAIN) && (dn != sb_n);
  assign mem_addr  = sba[dn[SBI-1:0]];
  assign mem_wdata = sbd[dn[SBI-1:0]];
  assign done      = (st == S_DONE);
  assign exit_idx  = exit_q;
endmodule

// File: rtl/trace_seq_chk.sv
module trace_seq_chk #(
  parameter int NREG = 8,
  parameter int SBDEPTH = 4,
  localparam int RW  = $clog2(NREG),
  localparam int SBW = $clog2(SBDEPTH + 1)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           done,
  input logic           lo_valid,
  input logic [RW-1:0]  lo_idx,
  input logic           mem_we,
  input logic [3:0]     st,
  input logic [SBW-1:0] sb_n
);
  localparam logic [3:0] P_EXE = 4'd3;
  localparam logic [3:0] P_WB  = 4'd4;
  localparam logic [3:0] P_SQ  = 4'd6;

  AST_LO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    lo_valid && $past(lo_valid) |-> lo_idx == RW'($past(lo_idx) + 1'b1)); // R2
  AST_WB_AFTER_EXE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == P_WB) && ($past(st) != P_WB) |-> $past(st) == P_EXE); // R4
  AST_DRAIN_AFTER_WB: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we && !$past(mem_we) |-> $past(st) == P_WB); // R6
  AST_LO_AFTER_SQUASH: assert property (@(posedge clk) disable iff (!rst_n)
    lo_valid && !$past(lo_valid) |-> $past(st) == P_SQ); // R7
  AST_SB_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    sb_n <= SBW'(SBDEPTH)); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_DONE_AFTER_LO: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(lo_valid) && $past(lo_idx) == RW'(NREG-1)); // R9
endmodule

bind trace_seq trace_seq_chk #(.NREG(NREG), .SBDEPTH(SBDEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .done(done), .lo_valid(lo_valid),
  .lo_idx(lo_idx), .mem_we(mem_we), .st(st), .sb_n(sb_n));

// File: tb/trace_seq_test.sv
module trace_seq_test;
  localparam int NREG = 8, DW = 16, CDEPTH = 16, SBDEPTH = 4, IMMW = 8;
  localparam int RW = 3, CAW = 4, CW = 3 + 3*RW + IMMW + 5;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, li_we = 0, start = 0;
  logic [CAW-1:0] cfg_addr = '0, tr_start = '0;
  logic [CW-1:0] cfg_wdata = '0;
  logic [RW-1:0] li_idx = '0;
  logic [DW-1:0] li_data = '0;
  logic [CAW:0] tr_len = '0;
  logic lo_valid, mem_we, done;
  logic [RW-1:0] lo_idx;
  logic [DW-1:0] lo_data, mem_addr, mem_wdata;
  logic [CAW-1:0] exit_idx;

  trace_seq #(.NREG(NREG), .DW(DW), .CDEPTH(CDEPTH), .SBDEPTH(SBDEPTH), .IMMW(IMMW)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .li_we(li_we), .li_idx(li_idx), .li_data(li_data), .start(start),
    .tr_start(tr_start), .tr_len(tr_len), .lo_valid(lo_valid), .lo_idx(lo_idx),
    .lo_data(lo_data), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .done(done), .exit_idx(exit_idx));

  always #5 clk = ~clk;

  typedef struct packed { logic kind; logic [DW-1:0] a; logic [DW-1:0] d; } item_t;
  item_t q[$];
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // monitor: pop expected stores (R6) and live-outs (R2)
  always @(negedge clk) begin
    if (rst_n && (mem_we || lo_valid)) begin
      item_t got, exp;
      got.kind = lo_valid;
      got.a = lo_valid ? DW'(lo_idx) : mem_addr;
      got.d = lo_valid ? lo_data : mem_wdata;
      if (q.size() == 0) chk(lo_valid ? "R2 unexpected live-out" : "R6/R7/R8 unexpected store",
                             {got.a, got.d}, 32'hx);
      else begin
        exp = q.pop_front();
        chk(exp.kind ? "R2 live-out" : "R6 store", {15'd0, got.kind, got.a, got.d},
            {15'd0, exp.kind, exp.a, exp.d});
      end
    end
  end

  function automatic logic [CW-1:0] enc(int op, int ra, int rb, int rd, int imm, int cl, int el, int wl);
    return {wl[0], el[2:0], cl[0], imm[IMMW-1:0], rd[RW-1:0], rb[RW-1:0], ra[RW-1:0], op[2:0]};
  endfunction

  task automatic wcfg(int addr, logic [CW-1:0] w);
    @(negedge clk); cfg_we = 1; cfg_addr = addr[CAW-1:0]; cfg_wdata = w;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic wli(int i, int v);
    @(negedge clk); li_we = 1; li_idx = i[RW-1:0]; li_data = v[DW-1:0];
    @(negedge clk); li_we = 0;
  endtask

  task automatic exp_store(int a, int d);
    q.push_back('{kind: 1'b0, a: a[DW-1:0], d: d[DW-1:0]});
  endtask

  task automatic exp_lo(int i, int d);
    q.push_back('{kind: 1'b1, a: i[DW-1:0], d: d[DW-1:0]});
  endtask

  task automatic run(string tag, int s, int len, int exp_cyc, int exp_exit);
    int cyc;
    @(negedge clk); start = 1; tr_start = s[CAW-1:0]; tr_len = len[CAW:0];
    @(posedge clk);
    @(negedge clk); start = 0;
    cyc = 1;
    while (!done && cyc < 5000) begin
      @(posedge clk); cyc++;
      @(negedge clk);
    end
    chk({tag, " R4 cycles start-to-done"}, cyc, exp_cyc);
    chk({tag, " R9 exit index"}, exit_idx, exp_exit);
    @(negedge clk);
    chk({tag, " R9 done one cycle"}, done, 0);
    chk({tag, " R2/R6 scoreboard drained"}, q.size(), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 done at reset", done, 0);
    chk("R1 lo_valid at reset", lo_valid, 0);
    chk("R1 mem_we at reset", mem_we, 0);
    rst_n = 1;

    // Program A: countdown loop, stores, guard exit, mixed latencies (R3 R4 R5 R6 R7)
    wcfg(2, enc(1, 2, 1, 2, 0, 0, 0, 0));
    wcfg(3, enc(5, 3, 2, 0, 0, 1, 4, 1));
    wcfg(4, enc(4, 3, 0, 3, 1, 0, 7, 0));
    wcfg(5, enc(6, 2, 0, 0, 0, 1, 2, 0));
    wli(0, 0); wli(1, 1); wli(2, 5); wli(3, 100);
    wli(4, 7); wli(5, 0); wli(6, 0); wli(7, 0);
    exp_store(100, 4); exp_store(101, 3); exp_store(102, 2); exp_store(103, 1);
    exp_lo(0, 0); exp_lo(1, 1); exp_lo(2, 1); exp_lo(3, 104);
    exp_lo(4, 7); exp_lo(5, 0); exp_lo(6, 0); exp_lo(7, 0);
    run("A", 2, 4, 147, 5);

    // Program B: fifth store in one iteration overflows (R8), ADDI result squashed (R7)
    wcfg(8, enc(4, 4, 0, 4, 8'hFD, 0, 0, 0));
    for (int k = 9; k <= 13; k++) wcfg(k, enc(5, 3, 4, 0, 0, 0, 0, 0));
    for (int i = 0; i < NREG; i++) wli(i, 16'h0A00 + i);
    for (int i = 0; i < NREG; i++) exp_lo(i, 16'h0A00 + i);
    run("B", 8, 6, 28, 13);

    // Program C: trace wraps past the last config entry, ALU ops, guard at bundle 0 (R3 R5)
    wcfg(14, enc(6, 0, 1, 0, 0, 0, 0, 0));
    wcfg(15, enc(4, 0, 0, 0, 1, 0, 0, 0));
    wcfg(0,  enc(0, 2, 3, 5, 0, 0, 0, 0));
    wcfg(1,  enc(3, 5, 4, 6, 0, 0, 0, 0));
    wcfg(2,  enc(2, 6, 2, 7, 0, 0, 0, 0));
    wcfg(3,  enc(4, 3, 0, 3, 8'hF0, 0, 0, 0));
    wli(0, 0); wli(1, 1); wli(2, 16'h1234); wli(3, 16'h0F0F);
    wli(4, 16'h00FF); wli(5, 0); wli(6, 0); wli(7, 0);
    exp_lo(0, 1); exp_lo(1, 1); exp_lo(2, 16'h1234); exp_lo(3, 16'h0EFF);
    exp_lo(4, 16'h00FF); exp_lo(5, 16'h2143); exp_lo(6, 16'h21BC); exp_lo(7, 16'h0034);
    run("C", 14, 6, 33, 14);

    summary();
  end
endmodule